// File: doc/BRIEF.md
# Register Rename Buffer

This block keeps one entry for each in-flight instruction that writes an architectural register. An instruction counts as in flight from the cycle it leaves issue until the cycle it leaves commit. In each cycle up to `LANES` instructions arrive from issue. Every lane whose instruction writes a register is given the next free entry, and the index of that entry becomes the lane's result tag. Lanes holding branches or stores get no entry. Each entry stores the identity of its owning instruction and a result-valid flag. The flag is clear at allocation. It is set, and the value captured, when a result broadcast names the entry's tag. The entry is then held until commit writes it back.

Entries are handed out and returned in program order through a circular head/tail pair and an occupancy count. If the register-writing instructions of an issue group need more entries than are free, the whole group stalls. A tag-indexed read port returns the value and valid flag of any entry for operand forwarding. Per-lane head ports show the oldest entries to the commit stage. A flush returns the buffer to empty.

Top module: `renameBuffer`

## Requirements
- R1: After reset, occupancy is 0, full is low, every headReady bit is low and readValid is low for every tag.
- R2: A lane is granted an entry only when its issueValid and issueWrites bits are both high and the group is not stalled. A lane with issueWrites low (branch or store) is never granted and is not counted toward a stall.
- R3: Granted tags are consecutive in lane order (lane 0 is the oldest). They start at the current tail, skip non-writing lanes and wrap modulo ENTRIES. The next cycle continues from the first unused tag.
- R4: issueStall is high exactly when the number of writing lanes exceeds ENTRIES minus occupancy. The occupancy used is the value at the start of the cycle, and commits in the same cycle are not credited. While stalled no lane is granted. full is high exactly when occupancy equals ENTRIES.
- R5: An entry reads back with valid 0 from allocation until a broadcast names its tag. From the next cycle after that broadcast, readValid is 1 and readData equals the broadcast value.
- R6: A broadcast that names a tag with no allocated entry has no effect: readValid for that tag stays 0.
- R7: Head lane l shows entry (head + l) mod ENTRIES. headReady is that entry's valid flag, headOwner is the issueOwner value of the lane that allocated it, and headData is its broadcast value.
- R8: A commitNum of k frees the min(k, occupancy) oldest entries, clears their valid flags and advances the head by that amount.
- R9: flush takes priority over every other input and empties the buffer. The first allocation after a flush receives tag 0.
- R10: After each clock edge, occupancy equals the previous occupancy plus the entries granted minus the entries freed. It never exceeds ENTRIES.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the buffer at the next edge |
| issueValid | input | LANES | Issue lane carries an instruction |
| issueWrites | input | LANES | Instruction in the lane writes an architectural register |
| issueOwner | input | LANES*ID_W | Instruction identity per lane, lane l at bits [l*ID_W +: ID_W] |
| issueStall | output | 1 | Too few free entries for the group's writers |
| allocGrant | output | LANES | Lane received an entry this cycle |
| allocTag | output | LANES*TAG_W | Result tag per lane, lane l at bits [l*TAG_W +: TAG_W] |
| bcastValid | input | BCAST | Result broadcast port active |
| bcastTag | input | BCAST*TAG_W | Tag named by each broadcast port |
| bcastData | input | BCAST*DATA_W | Result value on each broadcast port |
| readTag | input | TAG_W | Entry selected for forwarding |
| readValid | output | 1 | Selected entry holds a valid result |
| readData | output | DATA_W | Result value of the selected entry |
| commitNum | input | CMT_W | Number of oldest entries to release |
| headReady | output | LANES | Head entry l holds a valid result |
| headOwner | output | LANES*ID_W | Owner of head entry l |
| headData | output | LANES*DATA_W | Result value of head entry l |
| occupancy | output | CNT_W | Entries currently held |
| full | output | 1 | All entries held |

## Verification
An arithmetic sweep walks every combination of valid and write bits over both lanes. It pairs each combination with commit counts from 0 to 2 and with broadcasts that use one port, the other port, or both. Mixes with no writers separate correct skipping of branches and stores from simple lane-to-tag mapping. Mixes with one writer in lane 1 only show whether tags are ranked by writer rather than by lane. Phases weighted toward allocation drive the buffer to full, so the stall decision is tried against exact and insufficient room, and wraparound of both pointers is covered. Commits larger than the occupancy, broadcasts aimed at freed entries, and flushes in the middle of traffic separate clamping, ignore and restart behaviour from plain counting.

// File: rtl/rnb_pkg.sv
`timescale 1ns/1ps
package rnb_pkg;
  localparam int ENTRIES = 8;
  localparam int LANES   = 2;
  localparam int BCAST   = 2;
  localparam int ID_W    = 8;
  localparam int DATA_W  = 16;

  localparam int TAG_W  = $clog2(ENTRIES);
  localparam int CNT_W  = $clog2(ENTRIES + 1);
  localparam int CMT_W  = $clog2(LANES + 1);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  // strobes from control to datapath
  typedef struct packed {
    logic                           flush;
    logic [ENTRIES-1:0]             allocMask;
    logic [ENTRIES-1:0][LANE_W-1:0] allocLane;
    logic [ENTRIES-1:0]             freeMask;
  } strobe_t;

  function automatic logic [TAG_W-1:0] wrapTag(input logic [TAG_W-1:0] p, input int k);
    int s;
    s = int'(p) + k;
    return TAG_W'(s % ENTRIES);
  endfunction
endpackage

// File: rtl/rnb_ctrl.sv
`timescale 1ns/1ps
module rnb_ctrl
  import rnb_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   flush,
  input  logic [LANES-1:0]       issueValid,
  input  logic [LANES-1:0]       issueWrites,
  input  logic [CMT_W-1:0]       commitNum,
  output logic                   issueStall,
  output logic [LANES-1:0]       allocGrant,
  output logic [LANES*TAG_W-1:0] allocTag,
  output logic [CNT_W-1:0]       occupancy,
  output logic                   full,
  output logic [TAG_W-1:0]       headPtr,
  output strobe_t                strobes
);
  logic [TAG_W-1:0] headQ, tailQ;
  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] needNum, allocNum, freeNum, commitExt;

  // writers in the group and the stall decision
  always_comb begin : needCalc
    needNum = '0;
    for (int l = 0; l < LANES; l++) begin
      if (issueValid[l] && issueWrites[l]) needNum = needNum + CNT_W'(1);
    end
    issueStall = needNum > (CNT_W'(ENTRIES) - countQ);
    allocNum   = issueStall ? '0 : needNum;
    commitExt  = CNT_W'(commitNum);
    freeNum    = (commitExt > countQ) ? countQ : commitExt;
  end

  // tag assignment and strobe generation
  always_comb begin : strobeCalc
    logic [TAG_W-1:0] slot;
    slot               = tailQ;
    strobes.flush      = flush;
    strobes.allocMask  = '0;
    strobes.allocLane  = '0;
    strobes.freeMask   = '0;
    allocGrant         = '0;
    allocTag           = '0;
    for (int l = 0; l < LANES; l++) begin
      allocTag[l*TAG_W +: TAG_W] = slot;
      if (issueValid[l] && issueWrites[l]) begin
        if (!issueStall) begin
          allocGrant[l]             = 1'b1;
          strobes.allocMask[slot]   = 1'b1;
          strobes.allocLane[slot]   = LANE_W'(l);
        end
        slot = wrapTag(slot, 1);
      end
    end
    for (int k = 0; k < LANES; k++) begin
      if (CNT_W'(k) < freeNum) strobes.freeMask[wrapTag(headQ, k)] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      headQ  <= '0;
      tailQ  <= '0;
      countQ <= '0;
    end else begin
      headQ  <= wrapTag(headQ, int'(freeNum));
      tailQ  <= wrapTag(tailQ, int'(allocNum));
      countQ <= countQ + allocNum - freeNum;
    end
  end

  assign occupancy = countQ;
  assign full      = (countQ == CNT_W'(ENTRIES));
  assign headPtr   = headQ;
endmodule

// File: rtl/rnb_data.sv
`timescale 1ns/1ps
module rnb_data
  import rnb_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobes,
  input  logic [LANES*ID_W-1:0]   issueOwner,
  input  logic [BCAST-1:0]        bcastValid,
  input  logic [BCAST*TAG_W-1:0]  bcastTag,
  input  logic [BCAST*DATA_W-1:0] bcastData,
  input  logic [TAG_W-1:0]        headPtr,
  input  logic [TAG_W-1:0]        readTag,
  output logic                    readValid,
  output logic [DATA_W-1:0]       readData,
  output logic [LANES-1:0]        headReady,
  output logic [LANES*ID_W-1:0]   headOwner,
  output logic [LANES*DATA_W-1:0] headData
);
  logic [ENTRIES-1:0] validQ;
  logic [ID_W-1:0]    ownerQ [ENTRIES];
  logic [DATA_W-1:0]  dataQ  [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : gEntry
    logic              busy, valid, hit;
    logic [ID_W-1:0]   owner;
    logic [DATA_W-1:0] value, hitData;

    // later broadcast ports take precedence on a shared tag
    always_comb begin
      hit     = 1'b0;
      hitData = '0;
      for (int p = 0; p < BCAST; p++) begin
        if (bcastValid[p] && busy && bcastTag[p*TAG_W +: TAG_W] == TAG_W'(e)) begin
          hit     = 1'b1;
          hitData = bcastData[p*DATA_W +: DATA_W];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        busy  <= 1'b0;
        valid <= 1'b0;
        owner <= '0;
        value <= '0;
      end else if (strobes.flush) begin
        busy  <= 1'b0;
        valid <= 1'b0;
      end else if (strobes.allocMask[e]) begin
        busy  <= 1'b1;
        valid <= 1'b0;
        owner <= issueOwner[int'(strobes.allocLane[e])*ID_W +: ID_W];
      end else if (strobes.freeMask[e]) begin
        busy  <= 1'b0;
        valid <= 1'b0;
      end else if (hit) begin
        valid <= 1'b1;
        value <= hitData;
      end
    end

    assign validQ[e] = valid;
    assign ownerQ[e] = owner;
    assign dataQ[e]  = value;
  end

  assign readValid = validQ[readTag];
  assign readData  = dataQ[readTag];

  for (genvar l = 0; l < LANES; l++) begin : gHead
    logic [TAG_W-1:0] idx;
    assign idx                          = wrapTag(headPtr, l);
    assign headReady[l]                 = validQ[idx];
    assign headOwner[l*ID_W +: ID_W]    = ownerQ[idx];
    assign headData[l*DATA_W +: DATA_W] = dataQ[idx];
  end
endmodule

// File: rtl/renameBuffer.sv
`timescale 1ns/1ps
module renameBuffer
  import rnb_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    flush,
  input  logic [LANES-1:0]        issueValid,
  input  logic [LANES-1:0]        issueWrites,
  input  logic [LANES*ID_W-1:0]   issueOwner,
  output logic                    issueStall,
  output logic [LANES-1:0]        allocGrant,
  output logic [LANES*TAG_W-1:0]  allocTag,
  input  logic [BCAST-1:0]        bcastValid,
  input  logic [BCAST*TAG_W-1:0]  bcastTag,
  input  logic [BCAST*DATA_W-1:0] bcastData,
  input  logic [TAG_W-1:0]        readTag,
  output logic                    readValid,
  output logic [DATA_W-1:0]       readData,
  input  logic [CMT_W-1:0]        commitNum,
  output logic [LANES-1:0]        headReady,
  output logic [LANES*ID_W-1:0]   headOwner,
  output logic [LANES*DATA_W-1:0] headData,
  output logic [CNT_W-1:0]        occupancy,
  output logic                    full
);
  strobe_t          strobes;
  logic [TAG_W-1:0] headPtr;

  rnb_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .flush      (flush),
    .issueValid (issueValid),
    .issueWrites(issueWrites),
    .commitNum  (commitNum),
    .issueStall (issueStall),
    .allocGrant (allocGrant),
    .allocTag   (allocTag),
    .occupancy  (occupancy),
    .full       (full),
    .headPtr    (headPtr),
    .strobes    (strobes)
  );

  rnb_data uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .issueOwner(issueOwner),
    .bcastValid(bcastValid),
    .bcastTag  (bcastTag),
    .bcastData (bcastData),
    .headPtr   (headPtr),
    .readTag   (readTag),
    .readValid (readValid),
    .readData  (readData),
    .headReady (headReady),
    .headOwner (headOwner),
    .headData  (headData)
  );
endmodule

// File: rtl/renameBuffer_chk.sv
`timescale 1ns/1ps
module renameBuffer_chk
  import rnb_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             flush,
  input logic [LANES-1:0] issueValid,
  input logic [LANES-1:0] issueWrites,
  input logic [CMT_W-1:0] commitNum,
  input logic             issueStall,
  input logic [LANES-1:0] allocGrant,
  input logic [CNT_W-1:0] occupancy,
  input logic             full,
  input logic [LANES-1:0] headReady
);
  // R10
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(occupancy) <= ENTRIES);

  // R4
  grant_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(allocGrant) <= ENTRIES - int'(occupancy));

  // R2
  grant_writer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (allocGrant & ~(issueValid & issueWrites)) == '0);

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (occupancy == '0 && !full && headReady == '0));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && allocGrant == '0 && commitNum == '0) |=> $stable(occupancy));

  // R4
  full_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (full && (issueValid & issueWrites) != '0) |-> issueStall);
endmodule

bind renameBuffer renameBuffer_chk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .flush      (flush),
  .issueValid (issueValid),
  .issueWrites(issueWrites),
  .commitNum  (commitNum),
  .issueStall (issueStall),
  .allocGrant (allocGrant),
  .occupancy  (occupancy),
  .full       (full),
  .headReady  (headReady)
);

// File: tb/tb_renameBuffer.sv
`timescale 1ns/1ps
module tb_renameBuffer;
  import rnb_pkg::*;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    flush = 1'b0;
  logic [LANES-1:0]        issueValid = '0, issueWrites = '0;
  logic [LANES*ID_W-1:0]   issueOwner = '0;
  logic                    issueStall;
  logic [LANES-1:0]        allocGrant;
  logic [LANES*TAG_W-1:0]  allocTag;
  logic [BCAST-1:0]        bcastValid = '0;
  logic [BCAST*TAG_W-1:0]  bcastTag = '0;
  logic [BCAST*DATA_W-1:0] bcastData = '0;
  logic [TAG_W-1:0]        readTag = '0;
  logic                    readValid;
  logic [DATA_W-1:0]       readData;
  logic [CMT_W-1:0]        commitNum = '0;
  logic [LANES-1:0]        headReady;
  logic [LANES*ID_W-1:0]   headOwner;
  logic [LANES*DATA_W-1:0] headData;
  logic [CNT_W-1:0]        occupancy;
  logic                    full;

  renameBuffer dut (.*);

  always #5 clk = ~clk;

  int  checks = 0, failures = 0;
  bit  done = 1'b0;
  bit  mBusy [ENTRIES];
  bit  mValid[ENTRIES];
  int  mOwner[ENTRIES];
  int  mData [ENTRIES];
  int  mHead = 0, mTail = 0, mCount = 0;
  int  firstTag;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runCycle(input bit fl, input bit [1:0] v, input bit [1:0] w, input int cmt,
                          input bit [1:0] bv, input int bt0, input int bt1,
                          input int bd0, input int bd1, input int rd, input int ownBase);
    int need, rank, fn, idx;
    bit expStall, wr, expG;
    bit oldBusy[ENTRIES];
    int bts[2];
    int bds[2];
    @(negedge clk);
    flush = fl; issueValid = v; issueWrites = w;
    for (int l = 0; l < LANES; l++) issueOwner[l*ID_W +: ID_W] = ID_W'(ownBase + l);
    commitNum = CMT_W'(cmt);
    bcastValid = bv;
    bcastTag = {TAG_W'(bt1), TAG_W'(bt0)};
    bcastData = {DATA_W'(bd1), DATA_W'(bd0)};
    readTag = TAG_W'(rd);
    #1;
    // state left by the previous edge
    check(int'(occupancy) == mCount, "R8 R10 occupancy", occupancy, mCount);
    check(full == (mCount == ENTRIES), "R4 full", full, mCount == ENTRIES);
    for (int l = 0; l < LANES; l++) begin
      idx = (mHead + l) % ENTRIES;
      check(headReady[l] == mValid[idx], "R7 R8 headReady", headReady[l], mValid[idx]);
      if (mBusy[idx]) check(int'(headOwner[l*ID_W +: ID_W]) == mOwner[idx], "R7 headOwner",
                            headOwner[l*ID_W +: ID_W], mOwner[idx]);
      if (mValid[idx]) check(int'(headData[l*DATA_W +: DATA_W]) == mData[idx], "R7 headData",
                             headData[l*DATA_W +: DATA_W], mData[idx]);
    end
    check(readValid == mValid[rd], "R5 R6 readValid", readValid, mValid[rd]);
    if (mValid[rd]) check(int'(readData) == mData[rd], "R5 readData", readData, mData[rd]);
    // issue decision in this cycle
    need = 0;
    for (int l = 0; l < LANES; l++) if (v[l] && w[l]) need++;
    expStall = need > (ENTRIES - mCount);
    check(issueStall == expStall, "R4 stall", issueStall, expStall);
    rank = 0; firstTag = -1;
    for (int l = 0; l < LANES; l++) begin
      wr = v[l] && w[l];
      expG = wr && !expStall;
      check(allocGrant[l] == expG, "R2 grant", allocGrant[l], expG);
      if (expG) begin
        check(int'(allocTag[l*TAG_W +: TAG_W]) == (mTail + rank) % ENTRIES, "R3 tag",
              allocTag[l*TAG_W +: TAG_W], (mTail + rank) % ENTRIES);
        if (firstTag < 0) firstTag = int'(allocTag[l*TAG_W +: TAG_W]);
      end
      if (wr) rank++;
    end
    // model of the next state
    if (fl) begin
      for (int e = 0; e < ENTRIES; e++) begin mBusy[e] = 0; mValid[e] = 0; end
      mHead = 0; mTail = 0; mCount = 0;
    end else begin
      bts[0] = bt0; bts[1] = bt1; bds[0] = bd0; bds[1] = bd1;
      for (int e = 0; e < ENTRIES; e++) oldBusy[e] = mBusy[e];
      for (int p = 0; p < 2; p++) begin
        if (bv[p] && oldBusy[bts[p]]) begin
          mValid[bts[p]] = 1;
          mData[bts[p]] = bds[p] & ((1 << DATA_W) - 1);
        end
      end
      fn = (cmt < mCount) ? cmt : mCount;
      for (int k = 0; k < fn; k++) begin
        idx = (mHead + k) % ENTRIES;
        mBusy[idx] = 0; mValid[idx] = 0;
      end
      mHead = (mHead + fn) % ENTRIES;
      if (!expStall) begin
        rank = 0;
        for (int l = 0; l < LANES; l++) begin
          if (v[l] && w[l]) begin
            idx = (mTail + rank) % ENTRIES;
            mBusy[idx] = 1; mValid[idx] = 0;
            mOwner[idx] = (ownBase + l) & ((1 << ID_W) - 1);
            rank++;
          end
        end
        mTail = (mTail + need) % ENTRIES;
        mCount = mCount + need;
      end
      mCount = mCount - fn;
    end
  endtask

  initial begin : watchdog
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stimulus
    int v, w, cmt;
    for (int e = 0; e < ENTRIES; e++) begin mBusy[e] = 0; mValid[e] = 0; mOwner[e] = 0; mData[e] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    #1;
    check(occupancy == '0, "R1 occupancy", occupancy, 0);
    check(full == 1'b0, "R1 full", full, 0);
    check(headReady == '0, "R1 headReady", headReady, 0);
    for (int t = 0; t < ENTRIES; t++) begin
      readTag = TAG_W'(t);
      #1;
      check(readValid == 1'b0, "R1 readValid", readValid, 0);
    end

    // R6: broadcast to an empty buffer, then read that tag back
    runCycle(0, 2'b00, 2'b00, 0, 2'b01, 5, 0, 123, 0, 5, 0);
    runCycle(0, 2'b00, 2'b00, 0, 2'b00, 0, 0, 0, 0, 5, 0);
    // fill to full with no commits, then stall
    for (int c = 0; c < 4; c++) runCycle(0, 2'b11, 2'b11, 0, 2'b00, 0, 0, 0, 0, c, 10 + 2*c);
    runCycle(0, 2'b11, 2'b01, 0, 2'b00, 0, 0, 0, 0, 0, 40);  // R4 stall at full
    runCycle(0, 2'b11, 2'b00, 0, 2'b00, 0, 0, 0, 0, 0, 42);  // R2 no writers, no stall
    // R8 commit more than occupancy later in sweep; drain part now
    runCycle(0, 2'b00, 2'b00, 2, 2'b11, 0, 1, 7, 9, 0, 0);
    runCycle(0, 2'b00, 2'b00, 0, 2'b00, 0, 0, 0, 0, 0, 0);
    // R6: entry 0 is now free; broadcast to it must be ignored
    runCycle(0, 2'b00, 2'b00, 0, 2'b01, 0, 0, 77, 0, 0, 0);
    runCycle(0, 2'b00, 2'b00, 0, 2'b00, 0, 0, 0, 0, 0, 0);

    // arithmetic sweep
    for (int c = 0; c < 800; c++) begin
      v = c % 4;
      w = (c / 4) % 4;
      if ((c / 50) % 2 == 1) begin
        w = 3;
        cmt = (c % 3 == 0) ? 1 : 0;
      end else begin
        cmt = (c * 7 / 5) % 3;
      end
      runCycle(c % 97 == 96, 2'(v), 2'(w), cmt, 2'((c / 2) % 4), (3 * c) % 8, (5 * c + 1) % 8,
               c * 37, c * 53 + 11, c % 8, c * 2);
    end

    // R9 flush then first allocation from lane 1 alone
    runCycle(0, 2'b11, 2'b11, 0, 2'b00, 0, 0, 0, 0, 0, 90);
    runCycle(1, 2'b11, 2'b11, 0, 2'b00, 0, 0, 0, 0, 0, 92);
    runCycle(0, 2'b10, 2'b10, 0, 2'b00, 0, 0, 0, 0, 0, 94);
    check(firstTag == 0, "R9 first tag after flush", firstTag, 0);
    runCycle(0, 2'b00, 2'b00, 0, 2'b00, 0, 0, 0, 0, 0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule